// File: doc/BRIEF.md
# Monochrome LCD Panel Scan Controller

This block feeds a single-scan monochrome LCD panel from a packed frame buffer in system memory. Software supplies the panel width in 16-pixel units, the number of lines, the pixel depth (1, 2 or 4 bits) and the byte address where the frame starts. The block reads 32-bit words through a simple request/acknowledge memory port, unpacks them and drives a 4-bit parallel data bus with one pixel-clock pulse per group of four pixels.

A line-clock pulse closes each line, a frame marker stays high for the whole first line of each frame, and an AC-bias output changes level once per frame. For 2 and 4 bit pixels the grey level is reduced to on/off by a fixed threshold: a pixel is lit when the most significant bit of its value is set. When the display is switched off, every panel output and the memory request stay low.

Top module: `lcd_scan_ctrl`

## Requirements
- R1: `cfg_width` gives the panel width in 16-pixel units and is clamped to the range 2 to MAX_WIDTH/16. Each line carries exactly 4 × units `lcd_cl2` pulses and is followed by one `lcd_cl1` pulse, which comes directly after the final pixel-clock pulse.
- R2: The `cfg_bpp` code selects the pixel depth: 0 selects 1 bit, 1 selects 2 bits, and 2 or 3 select 4 bits. Pixels are taken from each 32-bit word starting at bit 0 and working upward. The n-th pixel of a 4-pixel group is driven on `lcd_data[n]`. A pixel is lit when the top bit of its field is 1.
- R3: Once `mem_req` is raised, it stays high and `mem_addr` stays unchanged until `mem_ack` is seen. `mem_ack` is a single-cycle pulse that carries `mem_rdata`. Within a frame, the fetched addresses are base, base+4, base+8, and so on.
- R4: A line may end part of the way through a word. The unused pixels of that word start the next line, and no extra fetch is made.
- R5: After the `lcd_cl1` pulse of the last line, the next fetch goes to `cfg_base`. Any pixels still unused in the current word are discarded. A `cfg_lines` value of 0 is treated as 1.
- R6: `lcd_frm` is high while the current line index is 0. This holds from the moment the display is enabled up to and including the `lcd_cl1` pulse of line 0, and it falls only right after a line-clock pulse.
- R7: `lcd_m` is low during the first frame after enable. It changes level only in the cycle after the `lcd_cl1` pulse of a frame's last line.
- R8: `cfg_err` rises when units × lines × 2 × bits-per-pixel exceeds 2^FB_BYTES_W bytes. The fetch offset always wraps modulo 2^FB_BYTES_W, so no address falls outside that window above the base.
- R9: One cycle after `enable` is seen low, `lcd_data`, `lcd_cl2`, `lcd_cl1`, `lcd_frm`, `lcd_m` and `mem_req` are all 0. Enabling again restarts the scan at line 0, at the base address, with `lcd_m` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Display on; low holds the panel outputs quiet |
| cfg_width | input | 7 | Panel width in 16-pixel units |
| cfg_lines | input | LINES_W | Lines per frame |
| cfg_bpp | input | 2 | Pixel depth code |
| cfg_base | input | ADDR_W | Frame buffer start byte address |
| mem_req | output | 1 | Word read request |
| mem_addr | output | ADDR_W | Byte address of requested word |
| mem_ack | input | 1 | Read data valid, one cycle |
| mem_rdata | input | 32 | Read data word |
| lcd_data | output | 4 | Four pixels, valid while lcd_cl2 is high |
| lcd_cl2 | output | 1 | Pixel clock pulse |
| lcd_cl1 | output | 1 | Line clock pulse |
| lcd_frm | output | 1 | Frame marker, high during line 0 |
| lcd_m | output | 1 | AC-bias drive |
| cfg_err | output | 1 | Configured frame exceeds the buffer window |

## Verification
The bench builds the block with FB_BYTES_W = 8, which shrinks the buffer window to 256 bytes, and with a 24-bit address. This lets an oversized frame be reached with a small panel, so the error flag and the wrap of the fetch address are exercised within a few hundred cycles. With narrow panels and only a few lines, each configuration runs two full frames. That covers the frame restart, the M toggle, lines that end in the middle of a word at 1 bit per pixel, and width clamping below the minimum, all well inside the cycle budget.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  typedef enum logic [1:0] {
    BPP_1 = 2'd0,
    BPP_2 = 2'd1,
    BPP_4 = 2'd2
  } bpp_e;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_FETCH = 2'd1,
    ST_SHIFT = 2'd2,
    ST_LINE  = 2'd3
  } scan_st_e;

  function automatic bpp_e decode_bpp(input logic [1:0] code);
    case (code)
      2'd0:    return BPP_1;
      2'd1:    return BPP_2;
      default: return BPP_4;
    endcase
  endfunction

  function automatic logic [1:0] bpp_log2(input bpp_e b);
    case (b)
      BPP_1:   return 2'd0;
      BPP_2:   return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/lcd_cfg_calc.sv
module lcd_cfg_calc
  import lcd_scan_pkg::*;
#(
  parameter int UNITS_W    = 7,
  parameter int MIN_UNITS  = 2,
  parameter int MAX_UNITS  = 64,
  parameter int LINES_W    = 10,
  parameter int NIB_W      = 8,
  parameter int FB_BYTES_W = 17
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [UNITS_W-1:0] cfg_width,
  input  logic [LINES_W-1:0] cfg_lines,
  input  logic [1:0]         cfg_bpp,
  output bpp_e               bpp_o,
  output logic [NIB_W-1:0]   nib_last_idx,
  output logic [LINES_W-1:0] line_last_idx,
  output logic               err_o
);
  localparam int FBYTES_W = UNITS_W + LINES_W + 4;
  localparam logic [FBYTES_W-1:0] FB_LIMIT = FBYTES_W'(1) << FB_BYTES_W;

  logic [UNITS_W-1:0]  units_eff;
  logic [LINES_W-1:0]  lines_eff;
  logic [FBYTES_W-1:0] frame_bytes;
  logic                err_d;

  always_comb begin
    if (cfg_width < UNITS_W'(MIN_UNITS))      units_eff = UNITS_W'(MIN_UNITS);
    else if (cfg_width > UNITS_W'(MAX_UNITS)) units_eff = UNITS_W'(MAX_UNITS);
    else                                      units_eff = cfg_width;
    lines_eff     = (cfg_lines == '0) ? LINES_W'(1) : cfg_lines;
    bpp_o         = decode_bpp(cfg_bpp);
    nib_last_idx  = NIB_W'({units_eff, 2'b00}) - NIB_W'(1);
    line_last_idx = lines_eff - LINES_W'(1);
    frame_bytes   = (FBYTES_W'(units_eff) * FBYTES_W'(lines_eff))
                    << (1 + int'(bpp_log2(bpp_o)));
    err_d         = frame_bytes > FB_LIMIT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_o <= 1'b0;
    else        err_o <= err_d;
  end

endmodule

// File: rtl/lcd_unpack.sv
module lcd_unpack
  import lcd_scan_pkg::*;
(
  input  logic [31:0] word_i,
  input  bpp_e        bpp_i,
  output logic [3:0]  nib_o,
  output logic [31:0] word_next_o,
  output logic [3:0]  nibs_per_word_o
);
  for (genvar k = 0; k < 4; k++) begin : g_pix
    assign nib_o[k] = (bpp_i == BPP_1) ? word_i[k]       :
                      (bpp_i == BPP_2) ? word_i[2*k + 1] :
                                         word_i[4*k + 3];
  end

  always_comb begin
    case (bpp_i)
      BPP_1: begin
        word_next_o     = word_i >> 4;
        nibs_per_word_o = 4'd8;
      end
      BPP_2: begin
        word_next_o     = word_i >> 8;
        nibs_per_word_o = 4'd4;
      end
      default: begin
        word_next_o     = word_i >> 16;
        nibs_per_word_o = 4'd2;
      end
    endcase
  end

endmodule

// File: rtl/lcd_raster.sv
module lcd_raster #(
  parameter int NIB_W   = 8,
  parameter int LINES_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               step_nib,
  input  logic               step_line,
  input  logic [NIB_W-1:0]   nib_last_idx,
  input  logic [LINES_W-1:0] line_last_idx,
  output logic               last_nib,
  output logic               last_line,
  output logic               first_line,
  output logic               m_o
);
  logic [NIB_W-1:0]   nib_q, nib_d;
  logic [LINES_W-1:0] line_q, line_d;
  logic               m_q, m_d;

  assign last_nib   = nib_q == nib_last_idx;
  assign last_line  = line_q == line_last_idx;
  assign first_line = line_q == '0;
  assign m_o        = m_q;

  always_comb begin
    nib_d  = nib_q;
    line_d = line_q;
    m_d    = m_q;
    if (restart) begin
      nib_d  = '0;
      line_d = '0;
      m_d    = 1'b0;
    end else begin
      if (step_nib) nib_d = last_nib ? '0 : nib_q + NIB_W'(1);
      if (step_line) begin
        if (last_line) begin
          line_d = '0;
          m_d    = ~m_q;
        end else begin
          line_d = line_q + LINES_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nib_q  <= '0;
      line_q <= '0;
      m_q    <= 1'b0;
    end else begin
      nib_q  <= nib_d;
      line_q <= line_d;
      m_q    <= m_d;
    end
  end

  // R1: the pixel index within a line never passes the configured end
  p_nib_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    nib_q <= nib_last_idx);

endmodule

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
  import lcd_scan_pkg::*;
#(
  parameter int MAX_WIDTH  = 1024,
  parameter int LINES_W    = 10,
  parameter int ADDR_W     = 32,
  parameter int FB_BYTES_W = 17,
  localparam int MAX_UNITS = MAX_WIDTH / 16,
  localparam int UNITS_W   = $clog2(MAX_UNITS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [UNITS_W-1:0] cfg_width,
  input  logic [LINES_W-1:0] cfg_lines,
  input  logic [1:0]         cfg_bpp,
  input  logic [ADDR_W-1:0]  cfg_base,
  output logic               mem_req,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic               mem_ack,
  input  logic [31:0]        mem_rdata,
  output logic [3:0]         lcd_data,
  output logic               lcd_cl2,
  output logic               lcd_cl1,
  output logic               lcd_frm,
  output logic               lcd_m,
  output logic               cfg_err
);
  localparam int MIN_UNITS = 2;
  localparam int NIB_W     = $clog2(MAX_UNITS * 4);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[1];

  bpp_e               bpp;
  logic [NIB_W-1:0]   nib_last_idx;
  logic [LINES_W-1:0] line_last_idx;
  logic [3:0]         nib, nibs_per_word;
  logic [31:0]        word_next;
  logic               last_nib, last_line, first_line, m_raw;

  scan_st_e               st_q, st_d;
  logic [31:0]            wbuf_q, wbuf_d;
  logic                   wbuf_en;
  logic [3:0]             wnib_q, wnib_d;
  logic [FB_BYTES_W-1:0]  off_q, off_d;
  logic                   restart, step_nib, step_line;

  lcd_cfg_calc #(
    .UNITS_W(UNITS_W), .MIN_UNITS(MIN_UNITS), .MAX_UNITS(MAX_UNITS),
    .LINES_W(LINES_W), .NIB_W(NIB_W), .FB_BYTES_W(FB_BYTES_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_s_n), .cfg_width(cfg_width), .cfg_lines(cfg_lines),
    .cfg_bpp(cfg_bpp), .bpp_o(bpp), .nib_last_idx(nib_last_idx),
    .line_last_idx(line_last_idx), .err_o(cfg_err)
  );

  lcd_unpack u_unpack (
    .word_i(wbuf_q), .bpp_i(bpp), .nib_o(nib), .word_next_o(word_next),
    .nibs_per_word_o(nibs_per_word)
  );

  assign restart   = !enable || (st_q == ST_OFF);
  assign step_nib  = enable && (st_q == ST_SHIFT);
  assign step_line = enable && (st_q == ST_LINE);

  lcd_raster #(.NIB_W(NIB_W), .LINES_W(LINES_W)) u_raster (
    .clk(clk), .rst_n(rst_s_n), .restart(restart), .step_nib(step_nib),
    .step_line(step_line), .nib_last_idx(nib_last_idx),
    .line_last_idx(line_last_idx), .last_nib(last_nib),
    .last_line(last_line), .first_line(first_line), .m_o(m_raw)
  );

  always_comb begin
    st_d   = st_q;
    wbuf_d = wbuf_q;
    wnib_d = wnib_q;
    off_d  = off_q;
    if (!enable) begin
      st_d   = ST_OFF;
      wnib_d = '0;
      off_d  = '0;
    end else begin
      case (st_q)
        ST_OFF: begin
          st_d   = ST_FETCH;
          wnib_d = '0;
          off_d  = '0;
        end
        ST_FETCH: begin
          if (mem_ack) begin
            wbuf_d = mem_rdata;
            wnib_d = nibs_per_word;
            off_d  = off_q + FB_BYTES_W'(4);
            st_d   = ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          wbuf_d = word_next;
          wnib_d = wnib_q - 4'd1;
          if (last_nib)            st_d = ST_LINE;
          else if (wnib_q == 4'd1) st_d = ST_FETCH;
        end
        default: begin
          if (last_line) begin
            wnib_d = '0;
            off_d  = '0;
            st_d   = ST_FETCH;
          end else if (wnib_q != 4'd0) begin
            st_d = ST_SHIFT;
          end else begin
            st_d = ST_FETCH;
          end
        end
      endcase
    end
  end

  assign wbuf_en = (st_q == ST_SHIFT) || ((st_q == ST_FETCH) && mem_ack);

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q   <= ST_OFF;
      wnib_q <= '0;
      off_q  <= '0;
    end else begin
      st_q   <= st_d;
      wnib_q <= wnib_d;
      off_q  <= off_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)     wbuf_q <= '0;
    else if (wbuf_en) wbuf_q <= wbuf_d;
  end

  assign mem_req  = (st_q == ST_FETCH);
  assign mem_addr = cfg_base + ADDR_W'(off_q);
  assign lcd_cl2  = (st_q == ST_SHIFT);
  assign lcd_data = lcd_cl2 ? nib : 4'd0;
  assign lcd_cl1  = (st_q == ST_LINE);
  assign lcd_frm  = (st_q != ST_OFF) && first_line;
  assign lcd_m    = (st_q != ST_OFF) && m_raw;

  // R3: a pending read keeps its request and address until acknowledged
  p_fetch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && enable) |=> (mem_req && $stable(mem_addr)));

  // R9: one cycle after enable is low, the panel side is quiet
  p_quiet_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (lcd_data == 4'd0 && !lcd_cl2 && !lcd_cl1 && !lcd_frm
                 && !lcd_m && !mem_req));

  // R1: a line clock pulse directly follows a pixel clock pulse
  p_line_after_pixels_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_cl1) |-> $past(lcd_cl2));

  // R7: the AC bias changes only right after a line clock while enabled
  p_m_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && (lcd_m != $past(lcd_m))) |-> $past(lcd_cl1));

  // R6: the frame marker ends only right after a line clock
  p_frm_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lcd_frm) && enable) |-> $past(lcd_cl1));

endmodule

// File: tb/lcd_scan_ctrl_bench.sv
module lcd_scan_ctrl_bench;
  localparam int FBW     = 8;
  localparam int AW      = 24;
  localparam int LW      = 10;

  typedef struct packed {
    logic [6:0]    units;
    logic [LW-1:0] lines;
    logic [1:0]    bpp;
    logic [AW-1:0] base;
    logic          err;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{7'd2, 10'd2, 2'd0, 24'h000100, 1'b0},
    '{7'd3, 10'd3, 2'd0, 24'h000204, 1'b0},
    '{7'd2, 10'd3, 2'd1, 24'h000040, 1'b0},
    '{7'd2, 10'd2, 2'd2, 24'h001000, 1'b0},
    '{7'd1, 10'd2, 2'd3, 24'h000080, 1'b0},
    '{7'd8, 10'd5, 2'd2, 24'h003000, 1'b1}
  };

  logic          clk, rst_n, enable;
  logic [6:0]    cfg_width;
  logic [LW-1:0] cfg_lines;
  logic [1:0]    cfg_bpp;
  logic [AW-1:0] cfg_base;
  logic          mem_req, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_rdata;
  logic [3:0]    lcd_data;
  logic          lcd_cl2, lcd_cl1, lcd_frm, lcd_m, cfg_err;

  lcd_scan_ctrl #(.MAX_WIDTH(1024), .LINES_W(LW), .ADDR_W(AW), .FB_BYTES_W(FBW))
  u_lcd_scan_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_width(cfg_width),
    .cfg_lines(cfg_lines), .cfg_bpp(cfg_bpp), .cfg_base(cfg_base),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .lcd_data(lcd_data), .lcd_cl2(lcd_cl2),
    .lcd_cl1(lcd_cl1), .lcd_frm(lcd_frm), .lcd_m(lcd_m), .cfg_err(cfg_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] memf(input logic [AW-1:0] a);
    return ({8'h00, a} * 32'h9E3779B1) ^ 32'hC3A55A3C;
  endfunction

  // memory model: one-cycle acknowledge
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else begin
      mem_ack   <= mem_req && !mem_ack;
      mem_rdata <= memf(mem_addr);
    end
  end

  // monitor state, expected values derived from the requirements
  logic          mon_on = 1'b0;
  int            m_units, m_lines, m_bits;
  logic [AW-1:0] m_base;
  int            exp_line, exp_nibi, exp_frame, fetch_idx;

  function automatic logic [3:0] exp_nib(input int line, input int nib);
    logic [3:0] r;
    for (int k = 0; k < 4; k++) begin
      int p, b, w;
      logic [AW-1:0] a;
      logic [31:0] d;
      p = line * m_units * 16 + nib * 4 + k;
      b = p * m_bits + m_bits - 1;
      w = b / 32;
      a = m_base + AW'((w * 4) % (1 << FBW));
      d = memf(a);
      r[k] = d[b % 32];
    end
    return r;
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (mon_on) begin
      if (lcd_cl2) begin
        chk(lcd_data == exp_nib(exp_line, exp_nibi), "R2 pixel nibble",
            lcd_data, exp_nib(exp_line, exp_nibi));
        chk(lcd_frm == (exp_line == 0), "R6 frame marker", lcd_frm, exp_line == 0);
        chk(lcd_m == exp_frame[0], "R7 bias level", lcd_m, exp_frame[0]);
        exp_nibi++;
      end
      if (lcd_cl1) begin
        chk(exp_nibi == m_units * 4, "R1 pixel clocks per line", exp_nibi, m_units * 4);
        chk(lcd_frm == (exp_line == 0), "R6 frame marker at line clock", lcd_frm, exp_line == 0);
        exp_nibi = 0;
        exp_line++;
        if (exp_line == m_lines) begin
          exp_line = 0;
          exp_frame++;
          fetch_idx = 0;
        end
      end
      if (mem_req && mem_ack) begin
        // R3 R4 R5 R8: sequential words, restart at base, wrap in window
        chk(mem_addr == m_base + AW'((fetch_idx * 4) % (1 << FBW)), "R3 fetch address",
            mem_addr, m_base + AW'((fetch_idx * 4) % (1 << FBW)));
        fetch_idx++;
      end
    end
  end

  task automatic check_quiet(input string tag);
    chk(lcd_data == 4'd0 && !lcd_cl2 && !lcd_cl1 && !lcd_frm && !lcd_m && !mem_req,
        tag, {lcd_data, lcd_cl2, lcd_cl1, lcd_frm, lcd_m, mem_req}, 0);
  endtask

  task automatic run_vec(input vec_t v, input int frames);
    int guard;
    @(negedge clk);
    enable    = 1'b0;
    cfg_width = v.units;
    cfg_lines = v.lines;
    cfg_bpp   = v.bpp;
    cfg_base  = v.base;
    repeat (3) @(negedge clk);
    chk(cfg_err == v.err, "R8 size error flag", cfg_err, v.err);
    check_quiet("R9 quiet while disabled");
    m_units   = (v.units < 2) ? 2 : ((v.units > 64) ? 64 : int'(v.units));
    m_lines   = (v.lines == 0) ? 1 : int'(v.lines);
    m_bits    = (v.bpp == 2'd0) ? 1 : ((v.bpp == 2'd1) ? 2 : 4);
    m_base    = v.base;
    exp_line  = 0;
    exp_nibi  = 0;
    exp_frame = 0;
    fetch_idx = 0;
    mon_on    = 1'b1;
    enable    = 1'b1;
    guard     = 0;
    while (exp_frame < frames && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    chk(exp_frame == frames, "R5 frames completed", exp_frame, frames);
    mon_on = 1'b0;
    enable = 1'b0;
    @(negedge clk);
    check_quiet("R9 quiet one cycle after disable");
  endtask

  initial begin
    rst_n     = 1'b0;
    enable    = 1'b0;
    cfg_width = '0;
    cfg_lines = '0;
    cfg_bpp   = '0;
    cfg_base  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_quiet("R9 reset state");
    chk(cfg_err == 1'b0, "R8 reset error flag", cfg_err, 0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], 2);

    // R9: stop in the middle of a frame, then restart from the top
    @(negedge clk);
    cfg_width = 7'd3; cfg_lines = 10'd3; cfg_bpp = 2'd0; cfg_base = 24'h000500;
    repeat (3) @(negedge clk);
    enable = 1'b1;
    repeat (23) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check_quiet("R9 quiet after mid-frame stop");
    run_vec('{7'd3, 10'd3, 2'd0, 24'h000500, 1'b0}, 1);

    // R5: zero lines behave as a single line
    run_vec('{7'd2, 10'd0, 2'd1, 24'h000600, 1'b0}, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    while (cycles < 150000) @(negedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=<150000", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule